// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

The block collects single-cycle event strobes from several peripheral groups into latched secondary flags. It folds each group into one primary status bit and drives a single active-low interrupt request line toward a host. Each secondary flag has its own enable mask. A secondary flag latches whether or not it is masked, but it reaches its group's primary bit only when unmasked. Each primary bit also has a mask, which gates it from the pin while its status stays readable.

The host reads the primary register to see which groups are pending. It then reads the matching secondary flag registers and clears the flags it has handled by writing ones to them. Primary bits are derived from the flags and cannot be written. A register port with single-cycle strobes gives access to the primary register, the primary mask, and a flag register and a mask register for each group.

Register map (8-bit address, 16-bit data): `0x00` primary status, `0x01` primary mask, `0x10+g` flags of group g, `0x20+g` secondary mask of group g. Groups 0 to 5 map to primary bits 15, 14, 13, 12, 11 and 8. A mask bit of 1 means masked.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all secondary flags read 0, and every secondary mask bit and primary mask bit reads 1. The primary mask register reads `0xF900`, `irq_n` is 1 and `rdata` is 0.
- R2: An event strobe bit sets its secondary flag, which is visible at `0x10+g`. The flag stays set until the host clears it.
- R3: Writing to `0x10+g` clears exactly the flags whose write-data bits are 1. A write of 0 changes nothing.
- R4: When an event strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A primary bit is 1 exactly when at least one flag of its group is set and not masked by its secondary mask bit.
- R6: The primary register at `0x00` places groups 0 to 5 at bits 15, 14, 13, 12, 11 and 8, and reads 0 in every other bit. Writes to it have no effect.
- R7: A primary bit whose primary mask bit is 1 still reads as set in the primary register but does not assert `irq_n`.
- R8: `irq_n` is registered. It goes low one clock edge after a flag update makes some primary bit unmasked and set, and it is high otherwise.
- R9: A read strobe returns data on `rdata` after the next clock edge. Mask registers read back the value last written.
- R10: A secondary flag latches its event even while its secondary mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_GRP*GRP_W | Event strobes; group g occupies bits g*GRP_W and up |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
The bench builds the block with its defaults: six groups of eight flags and the primary bit positions 15, 14, 13, 12, 11 and 8. These values exercise every primary position, the gap bits 9 and 10 that must read 0, and a full byte of flags in one group. With them the bench covers the event/clear collision, a group held up by one remaining flag, and a primary bit dropped by masking its last flag. It also checks the exact cycle in which the pin falls.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam logic [ADDR_W-1:0] PRIM_ADDR  = 8'h00;
  localparam logic [ADDR_W-1:0] PMASK_ADDR = 8'h01;
  localparam logic [ADDR_W-1:0] FLAG_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] SMASK_BASE = 8'h20;
  localparam int unsigned POS_W = 4;
endpackage

// File: rtl/irq_sec_group.sv
module irq_sec_group #(
  parameter int unsigned GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] evt,
  input  logic             clr_we,
  input  logic             msk_we,
  input  logic [GRP_W-1:0] wbits,
  output logic [GRP_W-1:0] flags,
  output logic [GRP_W-1:0] smask,
  output logic             prim
);
  logic [GRP_W-1:0] clr_bits;

  assign clr_bits = clr_we ? wbits : '0;

  // events are OR-ed in after clearing so a colliding strobe survives
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      smask <= '1;
    end else begin
      flags <= (flags & ~clr_bits) | evt;
      if (msk_we) smask <= wbits;
    end
  end

  assign prim = |(flags & ~smask);
endmodule

// File: rtl/irq_prim_pin.sv
module irq_prim_pin #(
  parameter int unsigned NUM_GRP = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_GRP-1:0] prim,
  input  logic               pm_we,
  input  logic [NUM_GRP-1:0] pm_wbits,
  output logic [NUM_GRP-1:0] pmask,
  output logic               irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pmask <= '1;
      irq_n <= 1'b1;
    end else begin
      if (pm_we) pmask <= pm_wbits;
      irq_n <= ~|(prim & ~pmask);
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GRP  = 6,
  parameter int unsigned GRP_W    = 8,
  parameter logic [NUM_GRP*POS_W-1:0] PRIM_POS = 24'h8BCDEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_GRP-1:0]       prim,
  input  logic [NUM_GRP-1:0]       pmask,
  input  logic [NUM_GRP*GRP_W-1:0] flags_all,
  input  logic [NUM_GRP*GRP_W-1:0] smask_all,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] prim_word;
  logic [DATA_W-1:0] pmask_word;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    prim_word  = '0;
    pmask_word = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      prim_word[PRIM_POS[g*POS_W +: POS_W]]  = prim[g];
      pmask_word[PRIM_POS[g*POS_W +: POS_W]] = pmask[g];
    end
  end

  always_comb begin
    nxt = '0;
    if (addr == PRIM_ADDR)  nxt = prim_word;
    if (addr == PMASK_ADDR) nxt = pmask_word;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr == FLAG_BASE + ADDR_W'(g))
        nxt = DATA_W'(flags_all[g*GRP_W +: GRP_W]);
      if (addr == SMASK_BASE + ADDR_W'(g))
        nxt = DATA_W'(smask_all[g*GRP_W +: GRP_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= nxt;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GRP  = 6,
  parameter int unsigned GRP_W    = 8,
  parameter logic [NUM_GRP*POS_W-1:0] PRIM_POS = 24'h8BCDEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_GRP*GRP_W-1:0] evt_i,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     irq_n
);
  logic [NUM_GRP*GRP_W-1:0] flags_all;
  logic [NUM_GRP*GRP_W-1:0] smask_all;
  logic [NUM_GRP-1:0]       prim_vec;
  logic [NUM_GRP-1:0]       pmask_q;
  logic [NUM_GRP-1:0]       pm_wbits;
  logic                     pm_we;
  logic                     unused_wdata;

  assign unused_wdata = ^wdata;
  assign pm_we = wr_en && (addr == PMASK_ADDR);

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++)
      pm_wbits[g] = wdata[PRIM_POS[g*POS_W +: POS_W]];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic clr_we, msk_we;
    assign clr_we = wr_en && (addr == FLAG_BASE + ADDR_W'(g));
    assign msk_we = wr_en && (addr == SMASK_BASE + ADDR_W'(g));

    irq_sec_group #(.GRP_W(GRP_W)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_i[g*GRP_W +: GRP_W]),
      .clr_we (clr_we),
      .msk_we (msk_we),
      .wbits  (wdata[GRP_W-1:0]),
      .flags  (flags_all[g*GRP_W +: GRP_W]),
      .smask  (smask_all[g*GRP_W +: GRP_W]),
      .prim   (prim_vec[g])
    );
  end

  irq_prim_pin #(.NUM_GRP(NUM_GRP)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .prim     (prim_vec),
    .pm_we    (pm_we),
    .pm_wbits (pm_wbits),
    .pmask    (pmask_q),
    .irq_n    (irq_n)
  );

  irq_read_mux #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .PRIM_POS(PRIM_POS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .addr      (addr),
    .prim      (prim_vec),
    .pmask     (pmask_q),
    .flags_all (flags_all),
    .smask_all (smask_all),
    .rdata     (rdata)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GRP  = 6,
  parameter int unsigned GRP_W    = 8,
  parameter logic [NUM_GRP*POS_W-1:0] PRIM_POS = 24'h8BCDEF
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_GRP*GRP_W-1:0] evt_i,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        rdata,
  input logic                     irq_n,
  input logic [NUM_GRP*GRP_W-1:0] flags,
  input logic [NUM_GRP-1:0]       prim,
  input logic [NUM_GRP-1:0]       pmask
);
  logic [DATA_W-1:0] used_bits;
  always_comb begin
    used_bits = '0;
    for (int g = 0; g < NUM_GRP; g++)
      used_bits[PRIM_POS[g*POS_W +: POS_W]] = 1'b1;
  end

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((flags & $past(flags)) == $past(flags)));

  // R4
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(evt_i)) == '0));

  // R8
  pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !$past(|(prim & ~pmask))));

  // R6
  prim_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == PRIM_ADDR) |=> ((rdata & ~used_bits) == '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .PRIM_POS(PRIM_POS)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .evt_i (evt_i),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .rdata (rdata),
  .irq_n (irq_n),
  .flags (flags_all),
  .prim  (prim_vec),
  .pmask (pmask_q)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NG = 6;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NG*GW-1:0] evt_i = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit rd_pend = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int g, input logic [7:0] bits);
    evt_i[g*GW +: GW] = bits;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);
    check("R1 rdata", rdata, 16'h0000);
    rd(8'h00, 16'h0000, "R1 primary");
    rd(8'h01, 16'hF900, "R1 pmask");
    rd(8'h20, 16'h00FF, "R1 smask g0");
    rd(8'h13, 16'h0000, "R1 flags g3");

    // masked flag still latches
    pulse(1, 8'h04);
    rd(8'h11, 16'h0004, "R10 masked flag latches");
    rd(8'h00, 16'h0000, "R5 masked secondary keeps primary low");
    // unmask secondary, primary still masked
    wr(8'h21, 16'h00FB);
    rd(8'h21, 16'h00FB, "R9 smask readback");
    rd(8'h00, 16'h4000, "R7 primary visible while masked");
    check("R7 pin stays high", {15'd0, irq_n}, 16'd1);
    // unmask primary for group 1
    wr(8'h01, 16'hB900);
    rd(8'h01, 16'hB900, "R9 pmask readback");
    check("R8 pin low", {15'd0, irq_n}, 16'd0);
    // write zero, write primary
    wr(8'h11, 16'h0000);
    rd(8'h11, 16'h0004, "R3 zero write no effect");
    wr(8'h00, 16'h0000);
    rd(8'h00, 16'h4000, "R6 primary not writable");
    // clear
    wr(8'h11, 16'h0004);
    rd(8'h11, 16'h0000, "R3 w1c clears");
    rd(8'h00, 16'h0000, "R5 primary drops");
    check("R8 pin high", {15'd0, irq_n}, 16'd1);
    // collision
    evt_i[1*GW +: GW] = 8'h04;
    wr(8'h11, 16'h0004);
    evt_i = '0;
    rd(8'h11, 16'h0004, "R4 event wins over clear");
    wr(8'h11, 16'h00FF);
    rd(8'h11, 16'h0000, "R2 flag cleared after handling");

    // multi-group
    wr(8'h25, 16'h0000);
    wr(8'h01, 16'hB800);
    evt_i[5*GW +: GW] = 8'h81;
    evt_i[0*GW +: GW] = 8'h01;
    @(negedge clk);
    evt_i = '0;
    rd(8'h00, 16'h0100, "R6 group 5 at bit 8");
    rd(8'h15, 16'h0081, "R2 two flags latched");
    rd(8'h10, 16'h0001, "R2 group 0 flag");
    wr(8'h15, 16'h0001);
    rd(8'h00, 16'h0100, "R5 remaining flag holds primary");
    wr(8'h25, 16'h0080);
    rd(8'h00, 16'h0000, "R5 masking last flag drops primary");
    rd(8'h15, 16'h0080, "R10 masked flag retained");
    check("R8 pin high after mask", {15'd0, irq_n}, 16'd1);

    // pin timing
    pulse(5, 8'h01);
    check("R8 pin one edge later still high", {15'd0, irq_n}, 16'd1);
    @(negedge clk);
    check("R8 pin low after register", {15'd0, irq_n}, 16'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule